// File: doc/BRIEF.md
# Paged Dual-Map Register Decoder

This block sits between a simple synchronous host port and the control registers of a network controller. The host sees a 32-byte window. The upper half of the window (address bit 4 set) holds 16 paged slots, and the lower half is left to other logic, so it always reads as zero here. Two fields pick which register a slot reaches. The first is a 2-bit page held in the command register. The second is a map bit held in the enhancement register. Map 0 is the default layout, used for ring-style buffering. Map 1 is the alternate layout, which gathers the registers used for linked-list buffering.

The block decodes every host access against the current map and page. It produces a one-hot write strobe and a clear-on-read strobe for the owners of the registers. It keeps the storage registers with their reset values and returns registered read data. Void bits always read as zero. Slots with nothing behind them return zero and ignore writes. The command register sits at slot 0 on every page of both maps, so software can always change the page.

Top module: `paged_reg_decoder`

## Requirements
- R1: After reset, regCmd is 0x21, regEnh is 0x00, regLink is 0x00, regCfg is 0x0A and hostRdata is 0x00. regBound has no defined reset value.
- R2: The page is regCmd[7:6]. The command register is reached at window address 0x10 on every page in both maps, and a write there loads all 8 bits.
- R3: The map is regEnh[3]. A value of 0 selects the default map and 1 selects the alternate map. The change applies from the access after the write.
- R4: In the default map, the slots are as follows (page:address): 0:0x13 is the boundary register, 0:0x1D is the count input, 1:0x1C is the config register and 2:0x17 is the enhancement register.
- R5: In the alternate map, the slots are as follows: 0:0x1D is the count input, 1:0x15 is the link register, 2:0x1B is the enhancement register and 3:0x12 is the config register. The enhancement and config registers therefore sit at different addresses in the two maps.
- R6: Void bits read as zero and are never stored. These are regEnh[2:0] and bits [7:6] of the config register as read (regCfg is 6 bits).
- R7: A read of any other location returns 0x00, including all addresses below 0x10. A write to such a location changes no register and raises no strobe.
- R8: hostRdata takes the value read at the clock edge where hostRd is high. It holds that value while hostRd is low.
- R9: cntClr is high, in the same cycle as hostRd, only when the read decodes to the count slot. That read returns cntIn as sampled at that edge.
- R10: wrStb is high, in the same cycle as hostWr, for exactly the decoded register. The bit order is 0 command, 1 enhancement, 2 boundary, 3 link and 4 config.
- R11: When hostRd and hostWr are high in the same cycle, the read decodes with the page and map in effect before the edge. A read of the written register returns its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 5 | Window address |
| hostRd | input | 1 | Read request |
| hostWr | input | 1 | Write request |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Registered read data |
| cntIn | input | 8 | Value of the clear-on-read counter from its owner |
| cntClr | output | 1 | Read side-effect strobe to the counter owner |
| wrStb | output | 5 | One-hot write strobe per register |
| regCmd | output | 8 | Command register |
| regEnh | output | 8 | Enhancement register |
| regBound | output | 8 | Boundary register |
| regLink | output | 8 | Link register |
| regCfg | output | 6 | Config register |

## Verification
A read and a write can fall in the same cycle. The hard case is a write that moves the page or the map while a read decodes against the old selection. The bench provokes this with directed cycles that read and write the command register together, and a read and write of the link register together. Random cycles then drive hostRd and hostWr independently over the whole window. A behavioural model judges each read against the page, map and register contents held before the edge.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_ENH   = 3'd2,
    SEL_BOUND = 3'd3,
    SEL_LINK  = 3'd4,
    SEL_CFG   = 3'd5,
    SEL_CNT   = 3'd6
  } regSel_e;

  typedef struct packed {
    logic    wrCmd;
    logic    wrEnh;
    logic    wrBound;
    logic    wrLink;
    logic    wrCfg;
    logic    rdCnt;
    logic    rdEn;
    regSel_e rdSel;
  } ctlStb_t;

  localparam int NUM_WR = 5;

  // slot offsets inside the paged half of the window
  localparam logic [3:0] OFF_CMD       = 4'h0;
  localparam logic [3:0] OFF_CNT       = 4'hD;
  localparam logic [3:0] OFF_BOUND_D   = 4'h3;
  localparam logic [3:0] OFF_CFG_D     = 4'hC;
  localparam logic [3:0] OFF_ENH_D     = 4'h7;
  localparam logic [3:0] OFF_LINK_A    = 4'h5;
  localparam logic [3:0] OFF_ENH_A     = 4'hB;
  localparam logic [3:0] OFF_CFG_A     = 4'h2;

endpackage

// File: rtl/prd_ctrl.sv
module prd_ctrl
  import prd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic              mapSel,
  output ctlStb_t           stb,
  output logic [NUM_WR-1:0] wrVec
);

  localparam int OFF_W = ADDR_W - 1;

  logic             inWin;
  logic [OFF_W-1:0] slotOff;
  regSel_e          hitSel;

  assign inWin   = hostAddr[ADDR_W-1];
  assign slotOff = hostAddr[OFF_W-1:0];

  function automatic regSel_e decodeSel(input logic win, input logic [OFF_W-1:0] off,
                                        input logic [PAGE_W-1:0] pg, input logic alt);
    regSel_e res;
    res = SEL_NONE;
    if (win) begin
      if (off == OFF_CMD) begin
        res = SEL_CMD;
      end else if (!alt) begin
        case (pg)
          2'd0: begin
            if (off == OFF_BOUND_D) res = SEL_BOUND;
            else if (off == OFF_CNT) res = SEL_CNT;
          end
          2'd1: if (off == OFF_CFG_D) res = SEL_CFG;
          2'd2: if (off == OFF_ENH_D) res = SEL_ENH;
          default: res = SEL_NONE;
        endcase
      end else begin
        case (pg)
          2'd0: if (off == OFF_CNT) res = SEL_CNT;
          2'd1: if (off == OFF_LINK_A) res = SEL_LINK;
          2'd2: if (off == OFF_ENH_A) res = SEL_ENH;
          2'd3: if (off == OFF_CFG_A) res = SEL_CFG;
          default: res = SEL_NONE;
        endcase
      end
    end
    return res;
  endfunction

  assign hitSel = decodeSel(inWin, slotOff, pageSel, mapSel);

  always_comb begin
    stb         = '0;
    stb.wrCmd   = hostWr && (hitSel == SEL_CMD);
    stb.wrEnh   = hostWr && (hitSel == SEL_ENH);
    stb.wrBound = hostWr && (hitSel == SEL_BOUND);
    stb.wrLink  = hostWr && (hitSel == SEL_LINK);
    stb.wrCfg   = hostWr && (hitSel == SEL_CFG);
    stb.rdEn    = hostRd;
    stb.rdSel   = hostRd ? hitSel : SEL_NONE;
    stb.rdCnt   = hostRd && (hitSel == SEL_CNT);
  end

  assign wrVec = {stb.wrCfg, stb.wrLink, stb.wrBound, stb.wrEnh, stb.wrCmd};

  // R10: at most one register strobed per write
  a_r10_wr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  // R7: no strobe without a host write
  a_r7_no_stray_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !hostWr |-> (wrVec == '0));

endmodule

// File: rtl/prd_dpath.sv
module prd_dpath
  import prd_pkg::*;
#(
  parameter int             DATA_W   = 8,
  parameter int             PAGE_W   = 2,
  parameter int             CFG_W    = 6,
  parameter int             MAP_BIT  = 3,
  parameter int             ENH_VOID = 3,
  parameter logic [DATA_W-1:0] CMD_RST  = 8'h21,
  parameter logic [DATA_W-1:0] ENH_RST  = 8'h00,
  parameter logic [DATA_W-1:0] LINK_RST = 8'h00,
  parameter logic [CFG_W-1:0]  CFG_RST  = 6'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] cntIn,
  output logic [DATA_W-1:0] hostRdata,
  output logic [PAGE_W-1:0] pageSel,
  output logic              mapSel,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] enhReg,
  output logic [DATA_W-1:0] boundReg,
  output logic [DATA_W-1:0] linkReg,
  output logic [CFG_W-1:0]  cfgReg
);

  localparam int CFG_PAD = DATA_W - CFG_W;

  logic [DATA_W-1:0] enhNext;
  logic [DATA_W-1:0] rdMux;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_enh_mask
      if (gi < ENH_VOID) begin : g_void
        assign enhNext[gi] = 1'b0;
      end else begin : g_live
        assign enhNext[gi] = hostWdata[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= CMD_RST;
      enhReg  <= ENH_RST;
      linkReg <= LINK_RST;
      cfgReg  <= CFG_RST;
    end else begin
      if (stb.wrCmd)  cmdReg  <= hostWdata;
      if (stb.wrEnh)  enhReg  <= enhNext;
      if (stb.wrLink) linkReg <= hostWdata;
      if (stb.wrCfg)  cfgReg  <= hostWdata[CFG_W-1:0];
    end
  end

  // boundary register has no defined reset value
  always_ff @(posedge clk) begin
    if (stb.wrBound) boundReg <= hostWdata;
  end

  assign pageSel = cmdReg[DATA_W-1 -: PAGE_W];
  assign mapSel  = enhReg[MAP_BIT];

  always_comb begin
    case (stb.rdSel)
      SEL_CMD:   rdMux = cmdReg;
      SEL_ENH:   rdMux = enhReg;
      SEL_BOUND: rdMux = boundReg;
      SEL_LINK:  rdMux = linkReg;
      SEL_CFG:   rdMux = {{CFG_PAD{1'b0}}, cfgReg};
      SEL_CNT:   rdMux = cntIn;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else if (stb.rdEn) hostRdata <= rdMux;
  end

  // R8: read data holds between reads
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(hostRdata));

  // R2: command write loads the full byte
  a_r2_cmd_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCmd |=> (cmdReg == $past(hostWdata)));

  // R7: registers stay put without a strobe
  a_r7_regs_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrCmd || stb.wrEnh || stb.wrLink || stb.wrCfg) |=>
      ($stable(cmdReg) && $stable(enhReg) && $stable(linkReg) && $stable(cfgReg)));

  // R9: count read returns the sampled input
  a_r9_cnt_data: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdCnt |=> (hostRdata == $past(cntIn)));

endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
  import prd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 2,
  parameter int CFG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [DATA_W-1:0] cntIn,
  output logic              cntClr,
  output logic [NUM_WR-1:0] wrStb,
  output logic [DATA_W-1:0] regCmd,
  output logic [DATA_W-1:0] regEnh,
  output logic [DATA_W-1:0] regBound,
  output logic [DATA_W-1:0] regLink,
  output logic [CFG_W-1:0]  regCfg
);

  ctlStb_t           stb;
  logic [PAGE_W-1:0] pageSel;
  logic              mapSel;

  prd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAddr (hostAddr),
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .pageSel  (pageSel),
    .mapSel   (mapSel),
    .stb      (stb),
    .wrVec    (wrStb)
  );

  prd_dpath #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .CFG_W(CFG_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWdata (hostWdata),
    .cntIn     (cntIn),
    .hostRdata (hostRdata),
    .pageSel   (pageSel),
    .mapSel    (mapSel),
    .cmdReg    (regCmd),
    .enhReg    (regEnh),
    .boundReg  (regBound),
    .linkReg   (regLink),
    .cfgReg    (regCfg)
  );

  assign cntClr = stb.rdCnt;

endmodule

// File: tb/paged_reg_decoder_bench.sv
`timescale 1ns/1ps
module paged_reg_decoder_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] hostAddr = '0;
  logic       hostRd = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [7:0] cntIn = '0;
  logic       cntClr;
  logic [4:0] wrStb;
  logic [7:0] regCmd, regEnh, regBound, regLink;
  logic [5:0] regCfg;

  always #4 clk = ~clk;

  paged_reg_decoder u_paged_reg_decoder (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .cntIn(cntIn), .cntClr(cntClr),
    .wrStb(wrStb), .regCmd(regCmd), .regEnh(regEnh), .regBound(regBound),
    .regLink(regLink), .regCfg(regCfg)
  );

  int vectors = 0;
  int fails = 0;

  // reference state
  logic [7:0] mCmd = 8'h21, mEnh = 8'h00, mBound = 8'h00, mLink = 8'h00, mRdata = 8'h00;
  logic [5:0] mCfg = 6'h0A;
  bit         boundKnown = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 0 none, 1 cmd, 2 enh, 3 bound, 4 link, 5 cfg, 6 cnt
  function automatic int mdec(input logic [4:0] a, input logic [1:0] pg, input logic alt);
    if (!a[4]) return 0;
    if (a[3:0] == 4'h0) return 1;
    if (!alt) begin
      if (pg == 0 && a[3:0] == 4'h3) return 3;
      if (pg == 0 && a[3:0] == 4'hD) return 6;
      if (pg == 1 && a[3:0] == 4'hC) return 5;
      if (pg == 2 && a[3:0] == 4'h7) return 2;
    end else begin
      if (pg == 0 && a[3:0] == 4'hD) return 6;
      if (pg == 1 && a[3:0] == 4'h5) return 4;
      if (pg == 2 && a[3:0] == 4'hB) return 2;
      if (pg == 3 && a[3:0] == 4'h2) return 5;
    end
    return 0;
  endfunction

  task automatic checkRegs(input string tag);
    chk({tag, " regCmd"}, regCmd, mCmd);
    chk({tag, " regEnh"}, regEnh, mEnh);
    chk({tag, " regLink"}, regLink, mLink);
    chk({tag, " regCfg"}, {2'b00, regCfg}, {2'b00, mCfg});
    if (boundKnown) chk({tag, " regBound"}, regBound, mBound);
  endtask

  task automatic step(input string tag, input bit rd, input bit wr, input logic [4:0] a,
                      input logic [7:0] d, input logic [7:0] c);
    int id;
    logic [7:0] rv;
    logic [4:0] expStb;
    hostRd = rd; hostWr = wr; hostAddr = a; hostWdata = d; cntIn = c;
    #1;
    id = mdec(a, mCmd[7:6], mEnh[3]);
    expStb = '0;
    if (wr && id >= 1 && id <= 5) expStb[id-1] = 1'b1;
    chk("R10 wrStb", {3'b000, wrStb}, {3'b000, expStb});
    chk("R9 cntClr", {7'b0, cntClr}, {7'b0, (rd && id == 6)});
    case (id)
      1: rv = mCmd;
      2: rv = mEnh;
      3: rv = mBound;
      4: rv = mLink;
      5: rv = {2'b00, mCfg};
      6: rv = c;
      default: rv = 8'h00;
    endcase
    @(posedge clk);
    #1;
    if (rd) mRdata = rv;
    if (wr) begin
      case (id)
        1: mCmd = d;
        2: mEnh = d & 8'hF8;
        3: begin mBound = d; boundKnown = 1; end
        4: mLink = d;
        5: mCfg = d[5:0];
        default: ;
      endcase
    end
    hostRd = 0; hostWr = 0;
    @(negedge clk);
    if (rd && id == 3 && !boundKnown) ;
    else chk({tag, " R8 hostRdata"}, hostRdata, mRdata);
    checkRegs({tag, " R7"});
  endtask

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hostRdata", hostRdata, 8'h00);
    chk("R1 regCmd", regCmd, 8'h21);
    chk("R1 regEnh", regEnh, 8'h00);
    chk("R1 regLink", regLink, 8'h00);
    chk("R1 regCfg", {2'b00, regCfg}, 8'h0A);

    // R2 command on page 0, R4 boundary in default map
    step("R2", 1, 0, 5'h10, 8'h00, 8'h00);
    step("R4", 0, 1, 5'h13, 8'h3C, 8'h00);
    step("R4", 1, 0, 5'h13, 8'h00, 8'h00);
    step("R8", 0, 0, 5'h13, 8'h00, 8'h00);
    // R4 count slot in default map
    step("R9", 1, 0, 5'h1D, 8'h00, 8'h5E);
    // page 1
    step("R2", 0, 1, 5'h10, 8'h41, 8'h00);
    step("R2", 1, 0, 5'h10, 8'h00, 8'h00);
    step("R4", 1, 0, 5'h1C, 8'h00, 8'h00);
    step("R6", 0, 1, 5'h1C, 8'hFF, 8'h00);
    step("R6", 1, 0, 5'h1C, 8'h00, 8'h00);
    step("R7", 1, 0, 5'h15, 8'h00, 8'h00);
    // page 2, enhancement, map switch
    step("R2", 0, 1, 5'h10, 8'h80, 8'h00);
    step("R3", 0, 1, 5'h17, 8'hFF, 8'h00);
    step("R5", 1, 0, 5'h17, 8'h00, 8'h00);
    step("R5", 1, 0, 5'h1B, 8'h00, 8'h00);
    step("R2", 1, 0, 5'h10, 8'h00, 8'h00);
    // alternate page 0
    step("R2", 0, 1, 5'h10, 8'h00, 8'h00);
    step("R7", 0, 1, 5'h13, 8'h55, 8'h00);
    step("R7", 1, 0, 5'h13, 8'h00, 8'h00);
    step("R9", 1, 0, 5'h1D, 8'h00, 8'h9A);
    // alternate page 1 link
    step("R2", 0, 1, 5'h10, 8'h40, 8'h00);
    step("R5", 0, 1, 5'h15, 8'hC3, 8'h00);
    step("R5", 1, 0, 5'h15, 8'h00, 8'h00);
    step("R7", 1, 0, 5'h1C, 8'h00, 8'h00);
    // R11 same-cycle read and write of link
    step("R11", 1, 1, 5'h15, 8'h77, 8'h00);
    step("R11", 1, 0, 5'h15, 8'h00, 8'h00);
    // R11 read+write command changes page; read sees old
    step("R11", 1, 1, 5'h10, 8'hC0, 8'h00);
    step("R5", 1, 0, 5'h12, 8'h00, 8'h00);
    // low half of window
    step("R7", 0, 1, 5'h00, 8'hFF, 8'h00);
    step("R7", 1, 0, 5'h00, 8'h00, 8'h00);
    step("R7", 1, 0, 5'h0D, 8'h00, 8'h11);
    // back to default map through the alternate offset
    step("R2", 0, 1, 5'h10, 8'h80, 8'h00);
    step("R3", 0, 1, 5'h1B, 8'h00, 8'h00);
    step("R3", 1, 0, 5'h17, 8'h00, 8'h00);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [4:0] ra;
      ra = 5'($urandom);
      if (($urandom % 4) != 0) ra[4] = 1'b1;
      step("R11", 1'($urandom), 1'($urandom), ra, 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule